// File: doc/BRIEF.md
# Register-to-Serial Command Bridge

This block is the low-speed control endpoint of a host link. Host software reaches it through an AXI4-Lite slave window. Register writes go to one of two places. Command words are queued in a small FIFO and then played out as SPI or I2C transactions toward board peripherals, such as an ADC that must be woken from power-down or an IO expander that switches front-end relays. Other registers form a general-purpose IO bank. Its outputs drive board control lines, and its inputs let the host read status reported by neighbouring on-chip logic.

Each queued word selects its bus, carries one data byte and may mark the end of a transaction. The serial engine shifts bytes MSB first. On SPI it holds chip select low across bytes until a byte marked last has gone out. On I2C it sends a start condition, eight data clocks and a ninth acknowledge clock, and it sends a stop after a byte marked last. A divider register sets the serial bit rate from the AXI clock.

Top module: `cmd_bridge`

## Requirements
- R1: After reset, no AXI response is pending, chip select is high, SCL is high, SDA is released, the outputs register is zero and the status register reads 0x01.
- R2: The write address and write data may arrive in either order or together. Offsets 0x00, 0x04, 0x08, 0x0C and 0x10 answer OKAY (2'b00) on both reads and writes. Every other offset answers SLVERR (2'b10) and changes nothing.
- R3: A write to offset 0x00 queues one word: bits [7:0] are the data, bit 8 marks the last byte and bit 9 selects the bus (0 SPI, 1 I2C). Words are sent in the order they were written, from a FIFO of DEPTH entries.
- R4: A command write while the FIFO is full is dropped and sets a sticky overflow flag in status bit 4. Any write to offset 0x04 clears this flag.
- R5: Status (offset 0x04) reads bit 0 FIFO empty, bit 1 FIFO full, bit 2 engine shifting, bit 3 NACK seen and bit 4 overflow. Reads of offset 0x00 return zero.
- R6: An SPI byte drives chip select low and presents 8 bits MSB first on MOSI, each valid at a rising SCLK edge. Chip select stays low between bytes and rises only after a byte marked last.
- R7: An I2C transaction begins with SDA falling while SCL is high. Each byte is sent as 8 data bits MSB first, followed by a ninth clock during which SDA is released and the line is sampled. A high sample sets the sticky NACK flag (status bit 3), which any write to offset 0x04 clears. After a byte marked last, the engine raises SCL once more with SDA low and then releases SDA while SCL is high (stop).
- R8: The divider register (offset 0x08, reset value DIV_RST, read/write) sets each serial half-bit to DIV+1 clock cycles, so rising serial clock edges within a byte are 2*(DIV+1) cycles apart.
- R9: The outputs register (offset 0x0C) drives the `gpo` pins and reads back the value written.
- R10: Offset 0x10 returns the `gpi` pins as sampled one clock earlier. A write to it answers OKAY and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | AXI and engine clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data (full-word writes) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data out |
| i2c_scl | output | 1 | I2C clock |
| i2c_sda_oe | output | 1 | Pull SDA low when high |
| i2c_sda_in | input | 1 | SDA line as seen on the board |
| gpo | output | GPIO_W | Board control outputs |
| gpi | input | GPIO_W | Status inputs from other logic |

## Verification
The bench builds the bridge with DEPTH=4 and DIV_RST=3, keeping GPIO_W=8, DIV_W=8 and ADDR_W=8. The shallow FIFO lets five back-to-back command writes fill it while a slow first byte (DIV=100) is still shifting, so a sixth write meets a full queue and the dropped word can be seen missing from the SPI stream. A small divider keeps the SPI and I2C transactions short. It also makes the spacing between serial clock edges easy to check exactly.

// File: rtl/cmd_bridge.sv
module cmd_bridge #(
  parameter int ADDR_W  = 8,
  parameter int DEPTH   = 16,
  parameter int GPIO_W  = 8,
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  output logic              i2c_scl,
  output logic              i2c_sda_oe,
  input  logic              i2c_sda_in,
  output logic [GPIO_W-1:0] gpo,
  input  logic [GPIO_W-1:0] gpi
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [2:0] A_CMD = 3'd0, A_STAT = 3'd1, A_DIV = 3'd2, A_OUT = 3'd3, A_IN = 3'd4, A_BAD = 3'd7;

  function automatic logic [2:0] decode(input logic [ADDR_W-1:0] a);
    if (a[1:0] == 2'b00 && a[ADDR_W-1:2] < 5) return a[4:2];
    return A_BAD;
  endfunction

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_ACK, S_END, S_STOP, S_STOP2} st_t;

  logic              aw_got, w_got, ovf, nack;
  logic [ADDR_W-1:0] aw_a;
  logic [31:0]       w_d, rmux;
  logic [DIV_W-1:0]  div_r, cnt;
  logic [GPIO_W-1:0] gpi_q;
  logic [9:0]        q [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic [CW-1:0]     fill;
  st_t               st;
  logic              ph, mode, last, active;
  logic [2:0]        bitn;
  logic [7:0]        sh;

  wire [2:0] wsel   = decode(aw_a);
  wire       do_wr  = aw_got & w_got & ~s_bvalid;
  wire       empty  = (fill == '0);
  wire       full   = (fill == CW'(DEPTH));
  wire       push   = do_wr && wsel == A_CMD && !full;
  wire       pop    = (st == S_IDLE) && !empty;
  wire       clr    = do_wr && wsel == A_STAT;
  wire       busy   = (st != S_IDLE);
  wire       tick   = busy && (cnt >= div_r);
  logic      unused_w;
  assign unused_w  = ^w_d[31:10];

  assign s_awready = ~aw_got;
  assign s_wready  = ~w_got;
  assign s_arready = ~s_rvalid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_got <= 1'b0; w_got <= 1'b0; aw_a <= '0; w_d <= '0;
      s_bvalid <= 1'b0; s_bresp <= 2'b00; ovf <= 1'b0;
      div_r <= DIV_W'(DIV_RST); gpo <= '0; gpi_q <= '0;
    end else begin
      gpi_q <= gpi;
      if (s_awvalid && s_awready) begin aw_got <= 1'b1; aw_a <= s_awaddr; end
      if (s_wvalid && s_wready)   begin w_got  <= 1'b1; w_d  <= s_wdata;  end
      if (do_wr) begin
        aw_got <= 1'b0; w_got <= 1'b0; s_bvalid <= 1'b1;
        s_bresp <= (wsel == A_BAD) ? 2'b10 : 2'b00;
        if (wsel == A_CMD && full) ovf <= 1'b1;
        if (clr) ovf <= 1'b0;
        if (wsel == A_DIV) div_r <= w_d[DIV_W-1:0];
        if (wsel == A_OUT) gpo   <= w_d[GPIO_W-1:0];
      end else if (s_bvalid && s_bready) s_bvalid <= 1'b0;
    end
  end

  always_comb begin
    case (decode(s_araddr))
      A_STAT:  rmux = {27'd0, ovf, nack, busy, full, empty};
      A_DIV:   rmux = 32'(div_r);
      A_OUT:   rmux = 32'(gpo);
      A_IN:    rmux = 32'(gpi_q);
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_rvalid <= 1'b0; s_rdata <= '0; s_rresp <= 2'b00;
    end else if (s_arvalid && s_arready) begin
      s_rvalid <= 1'b1; s_rdata <= rmux;
      s_rresp  <= (decode(s_araddr) == A_BAD) ? 2'b10 : 2'b00;
    end else if (s_rvalid && s_rready) s_rvalid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; fill <= '0;
    end else begin
      if (push) begin
        q[wp] <= w_d[9:0];
        wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      end
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ph <= 1'b0; bitn <= '0; sh <= '0; mode <= 1'b0;
      last <= 1'b0; active <= 1'b0; rp <= '0; nack <= 1'b0;
      spi_sclk <= 1'b0; spi_cs_n <= 1'b1; spi_mosi <= 1'b0;
      i2c_scl <= 1'b1; i2c_sda_oe <= 1'b0;
    end else begin
      if (clr) nack <= 1'b0;
      cnt <= (!busy || tick) ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: if (pop) begin
          {mode, last, sh} <= q[rp];
          rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
          ph <= 1'b0; bitn <= '0; active <= 1'b1;
          if (q[rp][9]) begin
            if (!active) begin i2c_sda_oe <= 1'b1; st <= S_START; end
            else st <= S_BIT;
          end else begin spi_cs_n <= 1'b0; st <= S_BIT; end
        end
        S_START: if (tick) begin i2c_scl <= 1'b0; st <= S_BIT; end
        S_BIT: if (tick) begin
          if (!ph) begin
            if (mode) begin i2c_scl <= 1'b0; i2c_sda_oe <= ~sh[7]; end
            else begin spi_sclk <= 1'b0; spi_mosi <= sh[7]; end
          end else begin
            if (mode) i2c_scl <= 1'b1; else spi_sclk <= 1'b1;
            sh <= sh << 1;
            bitn <= bitn + 1'b1;
            if (bitn == 3'd7) st <= mode ? S_ACK : S_END;
          end
          ph <= ~ph;
        end
        S_ACK: if (tick) begin
          if (!ph) begin i2c_scl <= 1'b0; i2c_sda_oe <= 1'b0; end
          else begin i2c_scl <= 1'b1; nack <= nack | i2c_sda_in; st <= S_END; end
          ph <= ~ph;
        end
        S_END: if (tick) begin
          ph <= 1'b0;
          if (mode) i2c_scl <= 1'b0; else spi_sclk <= 1'b0;
          if (!last) st <= S_IDLE;
          else if (mode) st <= S_STOP;
          else begin spi_cs_n <= 1'b1; active <= 1'b0; st <= S_IDLE; end
        end
        S_STOP: if (tick) begin
          if (!ph) i2c_sda_oe <= 1'b1;
          else begin i2c_scl <= 1'b1; st <= S_STOP2; end
          ph <= ~ph;
        end
        S_STOP2: if (tick) begin i2c_sda_oe <= 1'b0; active <= 1'b0; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_bresp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata) && $stable(s_rresp));
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    do_wr && wsel == A_CMD && full |=> ovf);
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clr |=> ovf);
  p_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
  p_csn_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> spi_cs_n);
endmodule

// File: tb/test_cmd_bridge.sv
module test_cmd_bridge;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic sclk, cs_n, mosi, scl, sda_oe;
  logic ack_en = 1'b1;
  logic [7:0] gpo, gpi = '0;
  wire sda_in = !(sda_oe || ack_en);

  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  cmd_bridge #(.ADDR_W(8), .DEPTH(DEPTH), .GPIO_W(8), .DIV_W(8), .DIV_RST(3)) i_cmd_bridge (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .i2c_scl(scl), .i2c_sda_oe(sda_oe), .i2c_sda_in(sda_in),
    .gpo(gpo), .gpi(gpi));

  // line monitor, sampled between edges
  int cyc = 0, spi_bits = 0, cs_rises = 0, last_rise = 0, spi_gap = 0;
  int i2c_bits = 0, starts = 0, stops = 0;
  logic [63:0] spi_sh = '0, i2c_sh = '0;
  logic p_sclk = 0, p_cs = 1, p_scl = 1, p_sda = 1;
  always @(negedge clk) begin
    logic sda;
    sda = !sda_oe;
    cyc++;
    if (sclk && !p_sclk) begin
      spi_bits++; spi_sh = {spi_sh[62:0], mosi};
      spi_gap = cyc - last_rise; last_rise = cyc;
    end
    if (cs_n && !p_cs) cs_rises++;
    if (scl && !p_scl) begin i2c_bits++; i2c_sh = {i2c_sh[62:0], sda}; end
    if (scl && p_scl && !sda && p_sda) starts++;
    if (scl && p_scl && sda && !p_sda) stops++;
    p_sclk = sclk; p_cs = cs_n; p_scl = scl; p_sda = sda;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_aw(input logic [7:0] a);
    logic r;
    @(negedge clk); awaddr = a; awvalid = 1;
    do begin r = awready; @(posedge clk); end while (!r);
    @(negedge clk); awvalid = 0;
  endtask

  task automatic send_w(input logic [31:0] d);
    logic r;
    @(negedge clk); wdata = d; wvalid = 1;
    do begin r = wready; @(posedge clk); end while (!r);
    @(negedge clk); wvalid = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input int order, output logic [1:0] resp);
    case (order)
      1: begin send_aw(a); repeat (3) @(negedge clk); send_w(d); end
      2: begin send_w(d); repeat (3) @(negedge clk); send_aw(a); end
      default: fork send_aw(a); send_w(d); join
    endcase
    @(negedge clk); bready = 1;
    while (!bvalid) @(negedge clk);
    resp = bresp;
    @(posedge clk); @(negedge clk); bready = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [1:0] resp);
    logic r;
    @(negedge clk); araddr = a; arvalid = 1;
    do begin r = arready; @(posedge clk); end while (!r);
    @(negedge clk); arvalid = 0; rready = 1;
    while (!rvalid) @(negedge clk);
    d = rdata; resp = rresp;
    @(posedge clk); @(negedge clk); rready = 0;
  endtask

  task automatic wait_idle;
    logic [31:0] s; logic [1:0] r;
    do begin repeat (8) @(negedge clk); rd(8'h04, s, r); end while (!(s[0] && !s[2]));
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [1:0] r;
    check("R1 cs_n", cs_n, 1); check("R1 scl", scl, 1); check("R1 sda_oe", sda_oe, 0);
    check("R1 gpo", gpo, 0); check("R1 bvalid/rvalid", {bvalid, rvalid}, 0);
    rd(8'h04, d, r); check("R1 R5 status", d, 32'h01);
    rd(8'h08, d, r); check("R8 divider reset", d, 3);
    rd(8'h00, d, r); check("R5 command read", {r, d}, 0);
  endtask

  task automatic t_gpio;
    logic [31:0] d; logic [1:0] r;
    wr(8'h0C, 32'h5A, 1, r); check("R2 aw-first resp", r, 2'b00);
    check("R9 gpo pins", gpo, 8'h5A);
    wr(8'h0C, 32'hC3, 2, r); check("R2 w-first resp", r, 2'b00);
    rd(8'h0C, d, r); check("R9 readback", d, 32'hC3);
    @(negedge clk); gpi = 8'hA5; repeat (2) @(negedge clk);
    rd(8'h10, d, r); check("R10 gpi read", d, 32'hA5);
    wr(8'h10, 32'h3C, 0, r); check("R10 write resp", r, 2'b00);
    rd(8'h10, d, r); check("R10 write ignored", d, 32'hA5);
    check("R10 gpo untouched", gpo, 8'hC3);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic [1:0] r;
    wr(8'h40, 32'hFF, 0, r); check("R2 write slverr", r, 2'b10);
    wr(8'h0D, 32'hFF, 1, r); check("R2 misaligned slverr", r, 2'b10);
    check("R2 gpo unchanged", gpo, 8'hC3);
    rd(8'h14, d, r); check("R2 read slverr", r, 2'b10);
    rd(8'h04, d, r); check("R2 status unchanged", d, 32'h01);
  endtask

  task automatic t_spi;
    logic [31:0] d; logic [1:0] r; int b0, c0;
    b0 = spi_bits; c0 = cs_rises;
    wr(8'h08, 2, 0, r); rd(8'h08, d, r); check("R8 divider readback", d, 2);
    wr(8'h00, 32'h0A5, 0, r); check("R3 cmd resp", r, 2'b00);
    rd(8'h04, d, r); check("R5 busy while shifting", d[2], 1);
    check("R6 cs low", cs_n, 0);
    wr(8'h00, 32'h13C, 0, r);
    repeat (20) @(negedge clk);
    check("R6 cs held between bytes", cs_rises - c0, 0);
    wait_idle;
    check("R6 bit count", spi_bits - b0, 16);
    check("R3 R6 spi data", spi_sh[15:0], 16'hA53C);
    check("R6 cs rises once", cs_rises - c0, 1);
    check("R8 edge spacing", spi_gap, 6);
  endtask

  task automatic t_i2c;
    logic [31:0] d; logic [1:0] r; int b0, s0, p0;
    b0 = i2c_bits; s0 = starts; p0 = stops; ack_en = 1;
    wr(8'h00, 32'h25A, 0, r);
    wr(8'h00, 32'h3C3, 0, r);
    wait_idle;
    check("R7 start count", starts - s0, 1);
    check("R7 stop count", stops - p0, 1);
    check("R7 clock count", i2c_bits - b0, 19);
    // two bytes with released ack clock, then the stop clock with SDA low
    check("R7 i2c bits", i2c_sh[18:0], {8'h5A, 1'b1, 8'hC3, 1'b1, 1'b0});
    rd(8'h04, d, r); check("R7 no nack", d[3], 0);
    ack_en = 0;
    wr(8'h00, 32'h377, 0, r);
    wait_idle;
    rd(8'h04, d, r); check("R7 nack set", d[3], 1);
    wr(8'h04, 0, 0, r);
    rd(8'h04, d, r); check("R7 nack cleared", d[3], 0);
    ack_en = 1;
  endtask

  task automatic t_overflow;
    logic [31:0] d; logic [1:0] r; int b0, c0;
    b0 = spi_bits; c0 = cs_rises;
    wr(8'h08, 100, 0, r);
    for (int i = 1; i <= DEPTH + 2; i++) wr(8'h00, 32'h110 + i, 0, r);
    rd(8'h04, d, r); check("R4 R5 full+ovf", d, 32'h16);
    rd(8'h04, d, r); check("R4 ovf sticky", d[4], 1);
    wr(8'h04, 0, 0, r);
    rd(8'h04, d, r); check("R4 ovf cleared", d, 32'h06);
    wr(8'h08, 0, 0, r);
    wait_idle;
    check("R4 dropped word not sent", spi_bits - b0, 40);
    check("R3 fifo order", spi_sh[39:0], 40'h1112131415);
    check("R6 one cs per last byte", cs_rises - c0, 5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset;
    t_gpio;
    t_unmapped;
    t_spi;
    t_i2c;
    t_overflow;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule